// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block is the machine-level exception controller of a small 32-bit integer core. It holds the trap vector base, the exception PC, the cause, the trap value and a scratch register. It serves CSR reads and writes over a plain address/data port. It also decides when the core must leave its sequential path, either to enter a trap handler or to return from one.

Three sources can request a trap in any cycle:
- an exception request from the fetch or load/store stages, carrying a cause code, a trap value and a PC;
- a taken jump or branch whose computed target is not word aligned;
- a SYSTEM instruction with a zero function field, which may be environment call, breakpoint, return-from-trap or an unsupported word.

The redirect and its target are combinational, so they appear in the same cycle as the request. The CSR updates that a trap causes take effect at the next rising clock edge. Only direct-mode vectoring is provided. Return from a trap simply reloads the PC from the saved exception PC.

Top module: `mtrap_unit`

## Requirements
- R1: A CSR write to the vector base (0x305) stores the data with bits [1:0] cleared. Writes to scratch (0x340), exception PC (0x341), cause (0x342) and trap value (0x343) store the data unchanged. `csr_rdata_o` returns the current content of the register at `csr_addr_i` in the same cycle.
- R2: Address 0x301 reads 0x40000100, which identifies a 32-bit base-integer-only machine. The identity addresses 0xF11 to 0xF14 read 0. Writes to any of these five addresses have no effect.
- R3: Every other CSR address, including the interrupt-pending address 0x344, reads 0 and drops writes.
- R4: The word 0x00000073 (environment call) raises `trap_o` and `redirect_o`, with `redirect_pc_o` equal to the vector base. At the next edge, cause becomes 11, trap value becomes 0 and exception PC becomes `instr_pc_i`.
- R5: The word 0x00100073 (breakpoint) traps in the same way as R4, with cause 3 and trap value 0.
- R6: The word 0x30200073 (return) raises `redirect_o` without `trap_o`, with `redirect_pc_o` equal to the current exception PC. It changes no CSR.
- R7: Any other word with opcode bits [6:0] = 0x73 and funct3 bits [14:12] = 0 traps with cause 2 (illegal instruction), and the trap value is the instruction word. A word with a different opcode or a nonzero funct3 is not acted on.
- R8: When `jmp_valid_i` is high and either of `jmp_target_i[1:0]` is set, the unit traps with cause 0, trap value equal to the target, and exception PC equal to `instr_pc_i`. An aligned target causes no redirect.
- R9: `exc_valid_i` traps with cause `exc_cause_i` (zero-extended), trap value `exc_tval_i` and exception PC `exc_pc_i`. Priority order is: exception request, then misaligned jump, then SYSTEM word.
- R10: When a trap and a CSR write arrive in the same cycle, the trap updates are applied and the CSR write is discarded.
- R11: After reset all writable CSRs read 0, and `redirect_o` and `trap_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| instr_pc_i | input | 32 | PC of the executing instruction |
| sys_valid_i | input | 1 | Instruction word below is executing |
| sys_insn_i | input | 32 | Executing instruction word |
| jmp_valid_i | input | 1 | A jump or taken branch is executing |
| jmp_target_i | input | 32 | Computed next PC of that jump |
| exc_valid_i | input | 1 | Exception request from fetch or load/store |
| exc_cause_i | input | 4 | Cause code of the request |
| exc_tval_i | input | 32 | Trap value of the request |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| redirect_o | output | 1 | Next PC must be taken from redirect_pc_o |
| redirect_pc_o | output | 32 | Trap entry or return target |
| trap_o | output | 1 | A trap is being entered this cycle |

## Verification
Several properties are checked on every cycle:
- the vector base never holds set low bits;
- every trap redirects to the vector base and latches the selected cause and exception PC at the next edge;
- a trap leaves the vector base untouched even when a CSR write is in flight;
- a return redirects to the saved exception PC and leaves the exception PC and cause untouched.

Other behaviour can only be shown by the bench's scenarios, which compare values read back through the CSR port:
- the read value of every one of the 4096 CSR addresses after a write;
- the sweep over all 16 request causes and all four target alignments;
- the fixed identity constants;
- source priority when requests collide;
- the discarding of a scratch write that coincides with a trap.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  localparam int unsigned CSR_AW  = 12;
  localparam int unsigned CAUSE_W = 4;

  localparam logic [CSR_AW-1:0] ADDR_ISA     = 12'h301;
  localparam logic [CSR_AW-1:0] ADDR_TVEC    = 12'h305;
  localparam logic [CSR_AW-1:0] ADDR_SCRATCH = 12'h340;
  localparam logic [CSR_AW-1:0] ADDR_EPC     = 12'h341;
  localparam logic [CSR_AW-1:0] ADDR_CAUSE   = 12'h342;
  localparam logic [CSR_AW-1:0] ADDR_TVAL    = 12'h343;

  localparam logic [6:0]  OPC_SYSTEM = 7'h73;
  localparam logic [31:0] WORD_ECALL  = 32'h0000_0073;
  localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;
  localparam logic [31:0] WORD_MRET   = 32'h3020_0073;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_FETCH_MISALIGN = 4'd0,
    CAUSE_FETCH_ACCESS   = 4'd1,
    CAUSE_ILLEGAL        = 4'd2,
    CAUSE_BREAK          = 4'd3,
    CAUSE_LOAD_MISALIGN  = 4'd4,
    CAUSE_LOAD_ACCESS    = 4'd5,
    CAUSE_STORE_MISALIGN = 4'd6,
    CAUSE_STORE_ACCESS   = 4'd7,
    CAUSE_ECALL_M        = 4'd11,
    CAUSE_FETCH_PAGE     = 4'd12,
    CAUSE_LOAD_PAGE      = 4'd13,
    CAUSE_STORE_PAGE     = 4'd15
  } cause_e;

  typedef enum logic [2:0] {
    SYS_NONE,
    SYS_ECALL,
    SYS_EBREAK,
    SYS_MRET,
    SYS_ILLEGAL
  } sys_op_e;

endpackage

// File: rtl/mtrap_sys_decode.sv
module mtrap_sys_decode
  import mtrap_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  output sys_op_e     op_o
);

  logic is_priv;
  assign is_priv = valid_i && (insn_i[6:0] == OPC_SYSTEM) && (insn_i[14:12] == 3'b000);

  always_comb begin
    op_o = SYS_NONE;
    if (is_priv) begin
      case (insn_i)
        WORD_ECALL:  op_o = SYS_ECALL;
        WORD_EBREAK: op_o = SYS_EBREAK;
        WORD_MRET:   op_o = SYS_MRET;
        default:     op_o = SYS_ILLEGAL;
      endcase
    end
  end

endmodule

// File: rtl/mtrap_trap_sel.sv
module mtrap_trap_sel
  import mtrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                 exc_valid_i,
  input  logic [CAUSE_W-1:0]   exc_cause_i,
  input  logic [XLEN-1:0]      exc_tval_i,
  input  logic [XLEN-1:0]      exc_pc_i,
  input  logic                 jmp_valid_i,
  input  logic [XLEN-1:0]      jmp_target_i,
  input  logic [XLEN-1:0]      instr_pc_i,
  input  sys_op_e              sys_op_i,
  input  logic [31:0]          sys_insn_i,
  output logic                 take_trap_o,
  output logic                 take_ret_o,
  output logic [CAUSE_W-1:0]   cause_o,
  output logic [XLEN-1:0]      tval_o,
  output logic [XLEN-1:0]      epc_o
);

  logic jmp_misaligned;
  assign jmp_misaligned = jmp_valid_i && (jmp_target_i[1:0] != 2'b00);

  // fixed priority: stage exception, misaligned jump, system word
  always_comb begin
    take_trap_o = 1'b0;
    take_ret_o  = 1'b0;
    cause_o     = CAUSE_FETCH_MISALIGN;
    tval_o      = '0;
    epc_o       = instr_pc_i;
    if (exc_valid_i) begin
      take_trap_o = 1'b1;
      cause_o     = exc_cause_i;
      tval_o      = exc_tval_i;
      epc_o       = exc_pc_i;
    end else if (jmp_misaligned) begin
      take_trap_o = 1'b1;
      cause_o     = CAUSE_FETCH_MISALIGN;
      tval_o      = jmp_target_i;
    end else begin
      unique case (sys_op_i)
        SYS_ECALL: begin
          take_trap_o = 1'b1;
          cause_o     = CAUSE_ECALL_M;
        end
        SYS_EBREAK: begin
          take_trap_o = 1'b1;
          cause_o     = CAUSE_BREAK;
        end
        SYS_ILLEGAL: begin
          take_trap_o = 1'b1;
          cause_o     = CAUSE_ILLEGAL;
          tval_o      = XLEN'(sys_insn_i);
        end
        SYS_MRET: take_ret_o = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mtrap_csr_regs.sv
module mtrap_csr_regs
  import mtrap_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     TVEC_ALIGN = 2,
  parameter logic [XLEN-1:0] ISA_WORD   = 32'h4000_0100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CSR_AW-1:0]  addr_i,
  input  logic               we_i,
  input  logic [XLEN-1:0]    wdata_i,
  output logic [XLEN-1:0]    rdata_o,
  input  logic               trap_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    trap_tval_i,
  input  logic [XLEN-1:0]    trap_epc_i,
  output logic [XLEN-1:0]    tvec_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    cause_o
);

  localparam logic [XLEN-1:0] TVEC_MASK = {{(XLEN-TVEC_ALIGN){1'b1}}, {TVEC_ALIGN{1'b0}}};

  logic [XLEN-1:0] tvec_q, epc_q, cause_q, tval_q, scratch_q;
  logic            wr_en;

  // a trap in the same cycle overrides software writes
  assign wr_en = we_i && !trap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tvec_q    <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      tval_q    <= '0;
      scratch_q <= '0;
    end else if (trap_i) begin
      epc_q   <= trap_epc_i;
      cause_q <= XLEN'(trap_cause_i);
      tval_q  <= trap_tval_i;
    end else if (wr_en) begin
      case (addr_i)
        ADDR_TVEC:    tvec_q    <= wdata_i & TVEC_MASK;
        ADDR_SCRATCH: scratch_q <= wdata_i;
        ADDR_EPC:     epc_q     <= wdata_i;
        ADDR_CAUSE:   cause_q   <= wdata_i;
        ADDR_TVAL:    tval_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  // identity addresses and unknown addresses fall to zero
  always_comb begin
    case (addr_i)
      ADDR_ISA:     rdata_o = ISA_WORD;
      ADDR_TVEC:    rdata_o = tvec_q;
      ADDR_SCRATCH: rdata_o = scratch_q;
      ADDR_EPC:     rdata_o = epc_q;
      ADDR_CAUSE:   rdata_o = cause_q;
      ADDR_TVAL:    rdata_o = tval_q;
      default:      rdata_o = '0;
    endcase
  end

  assign tvec_o  = tvec_q;
  assign epc_o   = epc_q;
  assign cause_o = cause_q;

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CSR_AW-1:0]  csr_addr_i,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  input  logic [XLEN-1:0]    instr_pc_i,
  input  logic               sys_valid_i,
  input  logic [31:0]        sys_insn_i,
  input  logic               jmp_valid_i,
  input  logic [XLEN-1:0]    jmp_target_i,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    exc_tval_i,
  input  logic [XLEN-1:0]    exc_pc_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic               trap_o
);

  sys_op_e            sys_op_w;
  logic               take_trap_w, take_ret_w;
  logic [CAUSE_W-1:0] cause_w;
  logic [XLEN-1:0]    tval_w, epc_sel_w;
  logic [XLEN-1:0]    tvec_w, epc_w, cause_reg_w;

  mtrap_sys_decode u_dec (
    .valid_i (sys_valid_i),
    .insn_i  (sys_insn_i),
    .op_o    (sys_op_w)
  );

  mtrap_trap_sel #(.XLEN(XLEN)) u_sel (
    .exc_valid_i  (exc_valid_i),
    .exc_cause_i  (exc_cause_i),
    .exc_tval_i   (exc_tval_i),
    .exc_pc_i     (exc_pc_i),
    .jmp_valid_i  (jmp_valid_i),
    .jmp_target_i (jmp_target_i),
    .instr_pc_i   (instr_pc_i),
    .sys_op_i     (sys_op_w),
    .sys_insn_i   (sys_insn_i),
    .take_trap_o  (take_trap_w),
    .take_ret_o   (take_ret_w),
    .cause_o      (cause_w),
    .tval_o       (tval_w),
    .epc_o        (epc_sel_w)
  );

  mtrap_csr_regs #(.XLEN(XLEN)) u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (csr_addr_i),
    .we_i         (csr_we_i),
    .wdata_i      (csr_wdata_i),
    .rdata_o      (csr_rdata_o),
    .trap_i       (take_trap_w),
    .trap_cause_i (cause_w),
    .trap_tval_i  (tval_w),
    .trap_epc_i   (epc_sel_w),
    .tvec_o       (tvec_w),
    .epc_o        (epc_w),
    .cause_o      (cause_reg_w)
  );

  assign trap_o        = take_trap_w;
  assign redirect_o    = take_trap_w || take_ret_w;
  assign redirect_pc_o = take_trap_w ? tvec_w : epc_w;

endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk
  import mtrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               csr_we_i,
  input logic               redirect_o,
  input logic [XLEN-1:0]    redirect_pc_o,
  input logic               trap_o,
  input logic [XLEN-1:0]    tvec,
  input logic [XLEN-1:0]    epc,
  input logic [XLEN-1:0]    cause_reg,
  input logic [XLEN-1:0]    epc_sel,
  input logic [CAUSE_W-1:0] cause_sel
);

  a_r1_tvec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvec[1:0] == 2'b00);

  a_r4_trap_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (redirect_o && redirect_pc_o == tvec));

  a_r9_epc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> epc == $past(epc_sel));

  a_r9_cause_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> cause_reg == XLEN'($past(cause_sel)));

  a_r10_trap_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && csr_we_i) |=> $stable(tvec));

  a_r6_ret_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !trap_o) |-> redirect_pc_o == epc);

  a_r6_ret_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !trap_o && !csr_we_i) |=> ($stable(epc) && $stable(cause_reg)));

endmodule

bind mtrap_unit mtrap_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_we_i      (csr_we_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .trap_o        (trap_o),
  .tvec          (tvec_w),
  .epc           (epc_w),
  .cause_reg     (cause_reg_w),
  .epc_sel       (epc_sel_w),
  .cause_sel     (cause_w)
);

// File: tb/sim_mtrap_unit.sv
`timescale 1ns/1ps
module sim_mtrap_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr;
  logic        csr_we;
  logic [31:0] csr_wdata, csr_rdata;
  logic [31:0] instr_pc;
  logic        sys_valid;
  logic [31:0] sys_insn;
  logic        jmp_valid;
  logic [31:0] jmp_target;
  logic        exc_valid;
  logic [3:0]  exc_cause;
  logic [31:0] exc_tval, exc_pc;
  logic        redirect, trap;
  logic [31:0] redirect_pc;

  always #4 clk = ~clk;

  mtrap_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_addr_i(csr_addr), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .instr_pc_i(instr_pc), .sys_valid_i(sys_valid), .sys_insn_i(sys_insn),
    .jmp_valid_i(jmp_valid), .jmp_target_i(jmp_target),
    .exc_valid_i(exc_valid), .exc_cause_i(exc_cause), .exc_tval_i(exc_tval), .exc_pc_i(exc_pc),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc), .trap_o(trap)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] m_tvec = 0, m_epc = 0, m_cause = 0, m_tval = 0, m_scratch = 0;
  localparam logic [11:0] VIEW[9] = '{12'h301, 12'h305, 12'h340, 12'h341, 12'h342,
                                      12'h343, 12'h344, 12'hF11, 12'hF14};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    case (a)
      12'h301: return 32'h4000_0100;
      12'h305: return m_tvec;
      12'h340: return m_scratch;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h343: return m_tval;
      default: return 32'h0;
    endcase
  endfunction

  task automatic idle();
    csr_we = 0; csr_addr = 0; csr_wdata = 0; instr_pc = 0;
    sys_valid = 0; sys_insn = 0; jmp_valid = 0; jmp_target = 0;
    exc_valid = 0; exc_cause = 0; exc_tval = 0; exc_pc = 0;
  endtask

  task automatic read_chk(string req, logic [11:0] a);
    csr_addr = a;
    #1;
    chk(req, csr_rdata, exp_rd(a));
  endtask

  task automatic view_all(string req);
    for (int i = 0; i < 9; i++) read_chk(req, VIEW[i]);
  endtask

  task automatic csr_write(logic [11:0] a, logic [31:0] v);
    @(negedge clk);
    csr_addr = a; csr_we = 1; csr_wdata = v;
    @(negedge clk);
    csr_we = 0;
    case (a)
      12'h305: m_tvec = v & 32'hFFFF_FFFC;
      12'h340: m_scratch = v;
      12'h341: m_epc = v;
      12'h342: m_cause = v;
      12'h343: m_tval = v;
      default: ;
    endcase
  endtask

  // stimulus is applied right after a falling edge; outputs checked 1 ns later
  task automatic fire(string req, bit exp_redir, bit exp_trap, logic [31:0] exp_pc,
                      logic [31:0] cause, logic [31:0] tval, logic [31:0] epc);
    #1;
    chk({req, " redirect"}, 32'(redirect), 32'(exp_redir));
    chk({req, " trap"}, 32'(trap), 32'(exp_trap));
    if (exp_redir) chk({req, " target"}, redirect_pc, exp_pc);
    @(negedge clk);
    idle();
    if (exp_trap) begin
      m_cause = cause; m_tval = tval; m_epc = epc;
    end
    view_all(req);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    #3;
    chk("R11 reset redirect", 32'(redirect), 0);
    chk("R11 reset trap", 32'(trap), 0);
    view_all("R11 reset value");
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    view_all("R11 after release");

    // exhaustive address sweep: write then read back
    for (int a = 0; a < 4096; a++) begin
      logic [31:0] v;
      string tag;
      v = {a[11:0], 4'h9, ~a[11:0], 4'hF};
      csr_write(a[11:0], v);
      case (a)
        'h305, 'h340, 'h341, 'h342, 'h343: tag = "R1 rw";
        'h301, 'hF11, 'hF12, 'hF13, 'hF14: tag = "R2 id";
        default: tag = "R3 unknown";
      endcase
      read_chk(tag, a[11:0]);
    end
    view_all("R3 after sweep");

    csr_write(12'h305, 32'h8000_0103);
    read_chk("R1 tvec mask", 12'h305);

    // every cause code from the stage exception port
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      exc_valid = 1; exc_cause = c[3:0];
      exc_tval = 32'hDEAD_0000 + c; exc_pc = 32'h0000_0200 + 4 * c;
      fire("R9 exc", 1, 1, m_tvec, c, 32'hDEAD_0000 + c, 32'h0000_0200 + 4 * c);
    end

    // all four target alignments
    for (int lo = 0; lo < 4; lo++) begin
      @(negedge clk);
      jmp_valid = 1; jmp_target = 32'h4000_0010 + lo; instr_pc = 32'h0000_0300;
      fire("R8 jump", lo != 0, lo != 0, m_tvec, 0, 32'h4000_0010 + lo, 32'h0000_0300);
    end

    @(negedge clk);
    sys_valid = 1; sys_insn = 32'h0000_0073; instr_pc = 32'h0000_0400;
    fire("R4 ecall", 1, 1, m_tvec, 11, 0, 32'h0000_0400);

    @(negedge clk);
    sys_valid = 1; sys_insn = 32'h0010_0073; instr_pc = 32'h0000_0404;
    fire("R5 ebreak", 1, 1, m_tvec, 3, 0, 32'h0000_0404);

    csr_write(12'h341, 32'h1234_5678);
    @(negedge clk);
    sys_valid = 1; sys_insn = 32'h3020_0073; instr_pc = 32'h0000_0408;
    fire("R6 mret", 1, 0, 32'h1234_5678, 0, 0, 0);

    begin
      logic [31:0] bad[4] = '{32'h1050_0073, 32'h0020_0073, 32'h3030_0073, 32'h0000_00F3};
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        sys_valid = 1; sys_insn = bad[i]; instr_pc = 32'h0000_0500 + 4 * i;
        fire("R7 illegal", 1, 1, m_tvec, 2, bad[i], 32'h0000_0500 + 4 * i);
      end
    end

    @(negedge clk);
    sys_valid = 1; sys_insn = 32'h3401_1073; instr_pc = 32'h0000_0600;
    fire("R7 funct3 nonzero", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    sys_valid = 1; sys_insn = 32'h0000_0013; instr_pc = 32'h0000_0604;
    fire("R7 other opcode", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    sys_valid = 0; sys_insn = 32'h0000_0073; instr_pc = 32'h0000_0608;
    fire("R4 not valid", 0, 0, 0, 0, 0, 0);

    // priority
    @(negedge clk);
    exc_valid = 1; exc_cause = 5; exc_tval = 32'h0000_0AAA; exc_pc = 32'h0000_0700;
    jmp_valid = 1; jmp_target = 32'h0000_0802; sys_valid = 1; sys_insn = 32'h0000_0073;
    instr_pc = 32'h0000_0704;
    fire("R9 priority exc", 1, 1, m_tvec, 5, 32'h0000_0AAA, 32'h0000_0700);
    @(negedge clk);
    jmp_valid = 1; jmp_target = 32'h0000_0801; sys_valid = 1; sys_insn = 32'h0010_0073;
    instr_pc = 32'h0000_0708;
    fire("R8 priority jump", 1, 1, m_tvec, 0, 32'h0000_0801, 32'h0000_0708);
    @(negedge clk);
    jmp_valid = 1; jmp_target = 32'h0000_0900; sys_valid = 1; sys_insn = 32'h0010_0073;
    instr_pc = 32'h0000_070C;
    fire("R5 aligned jump", 1, 1, m_tvec, 3, 0, 32'h0000_070C);

    // trap versus CSR write in the same cycle
    @(negedge clk);
    exc_valid = 1; exc_cause = 7; exc_tval = 32'h0000_0BBB; exc_pc = 32'h0000_0A00;
    csr_we = 1; csr_addr = 12'h340; csr_wdata = 32'hFEED_BEEF;
    fire("R10 scratch", 1, 1, m_tvec, 7, 32'h0000_0BBB, 32'h0000_0A00);
    @(negedge clk);
    sys_valid = 1; sys_insn = 32'h0000_0073; instr_pc = 32'h0000_0A04;
    csr_we = 1; csr_addr = 12'h341; csr_wdata = 32'h5555_5555;
    fire("R10 epc", 1, 1, m_tvec, 11, 0, 32'h0000_0A04);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule